// File: doc/BRIEF.md
# Time-of-Day Alarm Interrupt Controller

This block watches a running calendar clock and raises interrupts when the time reaches one of two programmed alarm settings. Each alarm has four BCD bytes: seconds, minutes, hours and day. Bit 7 of each byte acts as a "don't care" flag for that field. Setting these flags from the finest field upward gives a range of alarm rates, from once per second up to once per week.

The block does not count time itself. It samples the seconds, minutes, hours and day values when a one-cycle strobe marks a new second. A small sequencer handles this sampling. The sequencer has three states:
- `ST_HALT`: the clock is stopped, and strobes are dropped.
- `ST_WAIT`: the clock is running, and the sequencer waits for a strobe.
- `ST_EVAL`: the sampled time is compared with both alarms.

The transitions are:
- Halt-to-wait: the stop bit clears and no strobe is present.
- Halt-to-eval: the stop bit clears and a strobe arrives in the same cycle.
- Wait-to-eval: a strobe is accepted.
- Eval-to-eval: another strobe arrives right away.
- Eval-to-wait: no strobe arrives.
- Any state to halt: the stop bit is set.

A match during `ST_EVAL` sets a sticky request flag for that alarm. A control byte holds the following bits:
- a clock-stop bit;
- a write-lock bit;
- a routing bit, which either sends each alarm to its own active-low pin or merges both alarms onto the first pin;
- one interrupt enable per alarm.

Software reaches the registers through a simple port with separate read and write strobes. Write addresses are the read addresses with bit 7 set.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: For each alarm, a field whose stored bit 7 is 1 is excluded from the comparison. The alarm matches when every unmasked field equals the sampled time in bits 6..0. With all four bits 7 set, every accepted strobe matches.
- R2: A match is evaluated only for an accepted strobe. If the strobe is sampled at clock edge k, the flag and any enabled interrupt pin change after edge k+1 and not before.
- R3: A request flag stays set until its own alarm's registers are accessed. A read strobe at 0x07..0x0A or a write strobe at 0x87..0x8A clears flag 0. Addresses 0x0B..0x0E and 0x8B..0x8E clear flag 1. If a new match and a clear happen in the same cycle, the match wins.
- R4: The control byte is read at 0x0F and written at 0x8F. Its bits are: bit 7 stop, bit 6 write-lock, bit 2 routing, bit 1 enable 1, bit 0 enable 0. Bits 5..3 always read 0.
- R5: The status byte is read at 0x10. Bit 0 is flag 0 and bit 1 is flag 1. Bits 7..2 read 0, and writes never change the status byte.
- R6: While write-lock is 1, all register writes are dropped, except that a control write still loads bit 6 (write-lock) from the data.
- R7: With routing = 1, flag 0 AND enable 0 drives `int0_n` low, and flag 1 AND enable 1 drives `int1_n` low.
- R8: With routing = 0, `int0_n` is low when either enabled flag is set, and `int1_n` stays high.
- R9: A flag whose enable is 0 pulls no pin low but still shows in the status byte. Setting the enable later asserts the pin from the stored flag.
- R10: While the stop bit is 1, strobes are ignored and no flag is set.
- R11: After reset the control byte reads 0xC0 (stopped and locked), both flags are 0, the alarm bytes read 0x00, and both pins are high.
- R12: Alarm 0 bytes are read at 0x07 (seconds), 0x08 (minutes), 0x09 (hours) and 0x0A (day). Alarm 1 bytes are read at 0x0B..0x0E in the same field order. Each write address is the read address plus 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address (bit 7 set) |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (used for flag clearing) |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Combinational read data for rd_addr |
| sec_tick | input | 1 | One-cycle strobe marking a new second |
| time_sec | input | 8 | BCD seconds from the clock counter |
| time_min | input | 8 | BCD minutes |
| time_hr | input | 8 | BCD hours |
| time_day | input | 8 | Day of week |
| int0_n | output | 1 | Active-low interrupt 0 |
| int1_n | output | 1 | Active-low interrupt 1 |

## Verification
The hardest case to reach from the ports is a new match and a flag clear landing on the same clock edge. The match edge is one cycle after the strobe edge, so the bench raises the strobe and then places a read of an alarm 0 byte in the next cycle. It then checks that the pin stays low. Another difficult case is the write-lock recovery path: a control write while locked must change only the lock bit. The bench covers this by writing a full control value while locked and reading back which bits took effect.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

    localparam int NUM_ALM    = 2;
    localparam int NUM_FIELDS = 4;
    localparam int BYTE_W     = 8;

    // 7-bit register offsets; bit 7 of the bus address selects write
    localparam logic [6:0] ALM_BASE  = 7'h07;
    localparam logic [6:0] CTRL_OFS  = 7'h0F;
    localparam logic [6:0] STAT_OFS  = 7'h10;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_WAIT = 2'd1,
        ST_EVAL = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic stop;
        logic lock;
        logic route_split;
        logic en1;
        logic en0;
    } ctrl_t;

    typedef logic [NUM_FIELDS-1:0][BYTE_W-1:0]              tod_t;
    typedef logic [NUM_ALM-1:0][NUM_FIELDS-1:0][BYTE_W-1:0] alarm_bank_t;

endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
    import alarm_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output ctrl_t             ctrl_q,
    output alarm_bank_t       alarm_q,
    output logic [NUM_ALM-1:0] acc_clr
);

    localparam int SLOTS = NUM_ALM * NUM_FIELDS;

    logic [6:0] wr_ofs;
    logic [6:0] rd_ofs;
    logic       wr_sel;
    logic       rd_sel;

    assign wr_ofs = wr_addr[6:0];
    assign rd_ofs = rd_addr[6:0];
    assign wr_sel = wr_en && wr_addr[ADDR_W-1];
    assign rd_sel = rd_en && !rd_addr[ADDR_W-1];

    // per-alarm access detection, independent of write-lock
    genvar ga;
    generate
        for (ga = 0; ga < NUM_ALM; ga++) begin : g_acc
            localparam logic [6:0] LO = ALM_BASE + 7'(ga * NUM_FIELDS);
            localparam logic [6:0] HI = LO + 7'(NUM_FIELDS - 1);
            assign acc_clr[ga] = (wr_sel && wr_ofs >= LO && wr_ofs <= HI) ||
                                 (rd_sel && rd_ofs >= LO && rd_ofs <= HI);
        end
    endgenerate

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{stop: 1'b1, lock: 1'b1, route_split: 1'b0, en1: 1'b0, en0: 1'b0};
        end else if (wr_sel && wr_ofs == CTRL_OFS) begin
            ctrl_q.lock <= wr_data[6];
            if (!ctrl_q.lock) begin
                ctrl_q.stop        <= wr_data[7];
                ctrl_q.route_split <= wr_data[2];
                ctrl_q.en1         <= wr_data[1];
                ctrl_q.en0         <= wr_data[0];
            end
        end
    end

    // alarm byte storage
    genvar gs;
    generate
        for (gs = 0; gs < SLOTS; gs++) begin : g_slot
            localparam int AI = gs / NUM_FIELDS;
            localparam int FI = gs % NUM_FIELDS;
            localparam logic [6:0] OFS = ALM_BASE + 7'(gs);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    alarm_q[AI][FI] <= '0;
                end else if (wr_sel && wr_ofs == OFS && !ctrl_q.lock) begin
                    alarm_q[AI][FI] <= wr_data;
                end
            end
        end
    endgenerate

    AST_LOCK_HOLDS_ALARMS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.lock |=> $stable(alarm_q)) else $error("lock violated"); // R6
    AST_LOCK_HOLDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.lock |=> (ctrl_q.stop == $past(ctrl_q.stop) &&
                         ctrl_q.route_split == $past(ctrl_q.route_split) &&
                         ctrl_q.en1 == $past(ctrl_q.en1) &&
                         ctrl_q.en0 == $past(ctrl_q.en0))) else $error("ctrl lock violated"); // R6

endmodule

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  alarm_bank_t        alarm_q,
    input  tod_t               cap_time,
    output logic [NUM_ALM-1:0] hit
);

    genvar ga, gf;
    generate
        for (ga = 0; ga < NUM_ALM; ga++) begin : g_alm
            logic [NUM_FIELDS-1:0] field_ok;
            logic [NUM_FIELDS-1:0] mask_bits;
            for (gf = 0; gf < NUM_FIELDS; gf++) begin : g_fld
                assign mask_bits[gf] = alarm_q[ga][gf][BYTE_W-1];
                assign field_ok[gf]  = mask_bits[gf] ||
                    (alarm_q[ga][gf][BYTE_W-2:0] == cap_time[gf][BYTE_W-2:0]);
            end
            assign hit[ga] = &field_ok;

            AST_ALL_MASKED_HIT: assert property (@(posedge clk) disable iff (!rst_n)
                (&mask_bits) |-> hit[ga]) else $error("masked miss"); // R1
        end
    endgenerate

endmodule

// File: rtl/alarm_seq.sv
module alarm_seq
    import alarm_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stop,
    input  logic               tick,
    input  tod_t               time_in,
    input  logic [NUM_ALM-1:0] hit,
    input  logic [NUM_ALM-1:0] acc_clr,
    output tod_t               cap_time,
    output logic [NUM_ALM-1:0] flags_q
);

    seq_state_t state_q, state_d;
    logic               accept;
    logic               eval_now;
    logic [NUM_ALM-1:0] flags_d;

    assign accept = tick && !stop;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (!stop) state_d = tick ? ST_EVAL : ST_WAIT;
            ST_WAIT: begin
                if (stop)      state_d = ST_HALT;
                else if (tick) state_d = ST_EVAL;
            end
            ST_EVAL: begin
                if (stop)      state_d = ST_HALT;
                else if (tick) state_d = ST_EVAL;
                else           state_d = ST_WAIT;
            end
            default: state_d = ST_HALT;
        endcase
    end

    // outputs: evaluation strobe and flag update
    always_comb begin
        eval_now = (state_q == ST_EVAL);
        for (int i = 0; i < NUM_ALM; i++) begin
            flags_d[i] = (eval_now && hit[i]) || (flags_q[i] && !acc_clr[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_time <= '0;
            flags_q  <= '0;
        end else begin
            if (accept) cap_time <= time_in;
            flags_q <= flags_d;
        end
    end

    AST_RISE_ONLY_FROM_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_EVAL) |=> ((flags_q & ~$past(flags_q)) == '0)) else $error("early set"); // R2
    AST_STOP_FORCES_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (state_q == ST_HALT)) else $error("not halted"); // R10
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_clr[0] && !(state_q == ST_EVAL && hit[0])) |=> !flags_q[0]) else $error("no clear"); // R3

endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              sec_tick,
    input  logic [7:0]        time_sec,
    input  logic [7:0]        time_min,
    input  logic [7:0]        time_hr,
    input  logic [7:0]        time_day,
    output logic              int0_n,
    output logic              int1_n
);

    localparam int SLOTS = NUM_ALM * NUM_FIELDS;

    ctrl_t              ctrl_q;
    alarm_bank_t        alarm_q;
    logic [NUM_ALM-1:0] acc_clr;
    logic [NUM_ALM-1:0] hit;
    logic [NUM_ALM-1:0] flags_q;
    tod_t               cap_time;
    tod_t               time_in;
    logic               req0_en;
    logic               req1_en;

    assign time_in = {time_day, time_hr, time_min, time_sec};

    alarm_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .ctrl_q  (ctrl_q),
        .alarm_q (alarm_q),
        .acc_clr (acc_clr)
    );

    alarm_match u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .alarm_q  (alarm_q),
        .cap_time (cap_time),
        .hit      (hit)
    );

    alarm_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop     (ctrl_q.stop),
        .tick     (sec_tick),
        .time_in  (time_in),
        .hit      (hit),
        .acc_clr  (acc_clr),
        .cap_time (cap_time),
        .flags_q  (flags_q)
    );

    // interrupt routing
    assign req0_en = flags_q[0] && ctrl_q.en0;
    assign req1_en = flags_q[1] && ctrl_q.en1;
    assign int0_n  = !(ctrl_q.route_split ? req0_en : (req0_en || req1_en));
    assign int1_n  = !(ctrl_q.route_split && req1_en);

    // read mux
    always_comb begin
        rd_data = '0;
        if (!rd_addr[ADDR_W-1]) begin
            if (rd_addr[6:0] == CTRL_OFS) begin
                rd_data = {ctrl_q.stop, ctrl_q.lock, 3'b000,
                           ctrl_q.route_split, ctrl_q.en1, ctrl_q.en0};
            end else if (rd_addr[6:0] == STAT_OFS) begin
                rd_data = {6'b0, flags_q};
            end else begin
                for (int s = 0; s < SLOTS; s++) begin
                    if (rd_addr[6:0] == ALM_BASE + 7'(s))
                        rd_data = alarm_q[s / NUM_FIELDS][s % NUM_FIELDS];
                end
            end
        end
    end

    AST_INT1_IDLE_MERGED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.route_split |-> int1_n) else $error("int1 active merged"); // R8
    AST_NO_ENABLE_NO_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.en0 && !ctrl_q.en1) |-> (int0_n && int1_n)) else $error("gated pin"); // R9
    AST_STATUS_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == {1'b0, STAT_OFS}) |-> (rd_data[7:2] == 6'b0)) else $error("status pad"); // R5
    AST_ROUTE_SPLIT_INT0: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.route_split && !flags_q[0]) |-> int0_n) else $error("split int0"); // R7

endmodule

// File: tb/alarm_irq_ctrl_bench.sv
module alarm_irq_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       sec_tick = 1'b0;
    logic [7:0] time_sec = '0, time_min = '0, time_hr = '0, time_day = '0;
    logic       int0_n, int1_n;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_irq_ctrl u_alarm_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .sec_tick(sec_tick),
        .time_sec(time_sec), .time_min(time_min), .time_hr(time_hr), .time_day(time_day),
        .int0_n(int0_n), .int1_n(int1_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); rd_addr = a; #1 d = rd_data;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; rd_addr = a; #1 d = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic set_alarm(input int idx, input logic [7:0] s, input logic [7:0] m,
                             input logic [7:0] h, input logic [7:0] dy);
        logic [7:0] base;
        base = 8'h87 + 8'(idx * 4);
        wr(base, s); wr(base + 8'd1, m); wr(base + 8'd2, h); wr(base + 8'd3, dy);
    endtask

    task automatic tick(input logic [7:0] s, input logic [7:0] m,
                        input logic [7:0] h, input logic [7:0] dy);
        @(negedge clk); sec_tick = 1'b1;
        time_sec = s; time_min = m; time_hr = h; time_day = dy;
        @(negedge clk); sec_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_both();
        logic [7:0] d;
        rd(8'h07, d); rd(8'h0B, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        peek(8'h0F, d); chk("R11 ctrl reset", d, 8'hC0);
        peek(8'h10, d); chk("R11 status reset", d, 8'h00);
        peek(8'h0C, d); chk("R11 alarm reset", d, 8'h00);
        chk("R11 int0_n", {7'b0, int0_n}, 8'h01);
        chk("R11 int1_n", {7'b0, int1_n}, 8'h01);
    endtask

    task automatic t_protect();
        logic [7:0] d;
        wr(8'h87, 8'h15);
        peek(8'h07, d); chk("R6 locked alarm write", d, 8'h00);
        wr(8'h8F, 8'h07);
        peek(8'h0F, d); chk("R6 locked ctrl write only lock", d, 8'h80);
        wr(8'h8F, 8'h3F);
        peek(8'h0F, d); chk("R4 ctrl layout pad bits", d, 8'h07);
        wr(8'h87, 8'h15);
        peek(8'h07, d); chk("R6 unlocked write", d, 8'h15);
    endtask

    task automatic t_regmap();
        logic [7:0] d;
        set_alarm(0, 8'h11, 8'h22, 8'h33, 8'h44);
        set_alarm(1, 8'h55, 8'h66, 8'h77, 8'h01);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] exp;
            exp = (i < 4) ? 8'(8'h11 * (i + 1)) : ((i == 7) ? 8'h01 : 8'(8'h11 * (i + 1)));
            peek(8'h07 + 8'(i), d);
            chk("R12 alarm readback", d, exp);
        end
    endtask

    task automatic t_mask();
        logic [7:0] d;
        wr(8'h8F, 8'h05);
        set_alarm(1, 8'h59, 8'h59, 8'h23, 8'h07);
        set_alarm(0, 8'h80, 8'h80, 8'h80, 8'h80);
        tick(8'h01, 8'h02, 8'h03, 8'h04);
        chk("R1 all masked fires", {7'b0, int0_n}, 8'h00);
        rd(8'h07, d);
        chk("R3 clear by alarm0 read", {7'b0, int0_n}, 8'h01);
        set_alarm(0, 8'h30, 8'h80, 8'h80, 8'h80);
        tick(8'h29, 8'h02, 8'h03, 8'h04);
        chk("R1 sec mismatch", {7'b0, int0_n}, 8'h01);
        tick(8'h30, 8'h02, 8'h03, 8'h04);
        chk("R1 sec match", {7'b0, int0_n}, 8'h00);
        set_alarm(0, 8'h30, 8'h45, 8'h80, 8'h80);
        tick(8'h30, 8'h44, 8'h03, 8'h04);
        chk("R1 min mismatch", {7'b0, int0_n}, 8'h01);
        tick(8'h30, 8'h45, 8'h03, 8'h04);
        chk("R1 min match", {7'b0, int0_n}, 8'h00);
        set_alarm(0, 8'h30, 8'h45, 8'h12, 8'h80);
        tick(8'h30, 8'h45, 8'h11, 8'h04);
        chk("R1 hour mismatch", {7'b0, int0_n}, 8'h01);
        tick(8'h30, 8'h45, 8'h12, 8'h04);
        chk("R1 hour match", {7'b0, int0_n}, 8'h00);
        set_alarm(0, 8'h30, 8'h45, 8'h12, 8'h05);
        tick(8'h30, 8'h45, 8'h12, 8'h04);
        chk("R1 day mismatch", {7'b0, int0_n}, 8'h01);
        tick(8'h30, 8'h45, 8'h12, 8'h05);
        chk("R1 day match", {7'b0, int0_n}, 8'h00);
        rd(8'h07, d);
    endtask

    task automatic t_timing_sticky();
        logic [7:0] d;
        set_alarm(0, 8'h80, 8'h80, 8'h80, 8'h80);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        chk("R2 not after strobe edge", {7'b0, int0_n}, 8'h01);
        @(negedge clk);
        chk("R2 after second edge", {7'b0, int0_n}, 8'h00);
        repeat (5) @(negedge clk);
        chk("R3 sticky", {7'b0, int0_n}, 8'h00);
        rd(8'h0B, d);
        chk("R3 other alarm access keeps", {7'b0, int0_n}, 8'h00);
        rd(8'h0A, d);
        chk("R3 alarm0 day read clears", {7'b0, int0_n}, 8'h01);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0; rd_en = 1'b1; rd_addr = 8'h07;
        @(negedge clk); rd_en = 1'b0;
        chk("R3 set beats clear", {7'b0, int0_n}, 8'h00);
        rd(8'h07, d);
    endtask

    task automatic t_route();
        logic [7:0] d;
        wr(8'h8F, 8'h07);
        set_alarm(0, 8'h30, 8'h45, 8'h12, 8'h05);
        set_alarm(1, 8'h80, 8'h80, 8'h80, 8'h80);
        tick(8'h00, 8'h00, 8'h00, 8'h00);
        chk("R7 int1 from alarm1", {6'b0, int1_n, int0_n}, 8'h01);
        peek(8'h10, d); chk("R5 status flag1", d, 8'h02);
        set_alarm(0, 8'h80, 8'h80, 8'h80, 8'h80);
        tick(8'h00, 8'h00, 8'h00, 8'h00);
        chk("R7 both pins", {6'b0, int1_n, int0_n}, 8'h00);
        peek(8'h10, d); chk("R5 status both", d, 8'h03);
        clear_both();
    endtask

    task automatic t_merge();
        wr(8'h8F, 8'h03);
        set_alarm(0, 8'h30, 8'h45, 8'h12, 8'h05);
        tick(8'h00, 8'h00, 8'h00, 8'h00);
        chk("R8 merged int0 from alarm1", {6'b0, int1_n, int0_n}, 8'h02);
        clear_both();
    endtask

    task automatic t_enable();
        logic [7:0] d;
        wr(8'h8F, 8'h05);
        tick(8'h00, 8'h00, 8'h00, 8'h00);
        chk("R9 disabled no pin", {6'b0, int1_n, int0_n}, 8'h03);
        peek(8'h10, d); chk("R9 flag still set", d, 8'h02);
        wr(8'h8F, 8'h07);
        chk("R9 late enable asserts", {6'b0, int1_n, int0_n}, 8'h01);
        clear_both();
    endtask

    task automatic t_halt();
        logic [7:0] d;
        wr(8'h8F, 8'h85);
        set_alarm(0, 8'h80, 8'h80, 8'h80, 8'h80);
        tick(8'h00, 8'h00, 8'h00, 8'h00);
        peek(8'h10, d); chk("R10 stopped no flag", d, 8'h00);
        chk("R10 stopped pin", {7'b0, int0_n}, 8'h01);
        wr(8'h8F, 8'h05);
        repeat (2) @(negedge clk);
        tick(8'h00, 8'h00, 8'h00, 8'h00);
        chk("R10 restart fires", {7'b0, int0_n}, 8'h00);
        clear_both();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_protect();
        t_regmap();
        t_mask();
        t_timing_sticky();
        t_route();
        t_merge();
        t_enable();
        t_halt();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule